// File: doc/BRIEF.md
# Single-Cycle Core Control Decoder

This block turns the opcode and function fields of a 32-bit instruction into the control signals a single-cycle datapath needs for five instruction kinds: register-register arithmetic and logic, word load, word store, branch-if-equal and unconditional jump. It is purely combinational. Its outputs are valid in the same cycle the fields are presented, so the datapath can fetch, execute and write back in one clock.

Decoding happens in two levels. A main decoder reads only the 6-bit opcode. It produces the datapath steering and enable signals plus a 2-bit ALU class. A second stage turns that class into a 4-bit ALU operation code. It looks at the 6-bit function field only when the class calls for it, which is the case for register-register instructions. An opcode or function code that is not recognised leaves every write enable low, so the architectural state is not touched.

Top module: `ctrl_decoder`

## Requirements
- R1: Opcode 0x00 (register-register) sets dest_sel_rd_o=1, alu_src_imm_o=0, mem_rd_en_o=0, mem_wr_en_o=0, wb_sel_mem_o=0, branch_o=0, jump_o=0 and alu_class_o=2'b10. It sets rf_wr_en_o=1 when the function code is recognised.
- R2: When the opcode is 0x00, the function codes 0x20, 0x22, 0x24, 0x25 and 0x2A produce the ALU operation codes 0010 (add), 0110 (subtract), 0000 (and), 0001 (or) and 0111 (set-less-than).
- R3: When the opcode is 0x00 and the function code is any other value, the decoder drives rf_wr_en_o=0, mem_wr_en_o=0 and alu_op_o=1111. All other outputs stay as in R1.
- R4: Opcode 0x23 (load word) sets rf_wr_en_o, alu_src_imm_o, mem_rd_en_o and wb_sel_mem_o to 1. It clears every other control, sets alu_class_o=00 and sets alu_op_o=0010 (add).
- R5: Opcode 0x2B (store word) sets alu_src_imm_o and mem_wr_en_o to 1. It clears every other control, sets alu_class_o=00 and sets alu_op_o=0010.
- R6: Opcode 0x04 (branch-if-equal) sets branch_o=1 and clears every other control. It sets alu_class_o=01 and alu_op_o=0110 (subtract).
- R7: Opcode 0x02 (jump) sets jump_o=1 and clears every other control. It sets alu_class_o=00 and alu_op_o=0010.
- R8: Any other opcode clears every control output, sets alu_class_o=00 and sets alu_op_o=0010.
- R9: For any opcode other than 0x00, the function field has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Instruction bits 31:26 |
| funct_i | input | 6 | Instruction bits 5:0 |
| dest_sel_rd_o | output | 1 | Write-back register taken from bits 15:11 instead of 20:16 |
| rf_wr_en_o | output | 1 | Register file write enable |
| alu_src_imm_o | output | 1 | ALU second operand is the sign-extended immediate |
| mem_rd_en_o | output | 1 | Data memory read enable |
| mem_wr_en_o | output | 1 | Data memory write enable |
| wb_sel_mem_o | output | 1 | Write-back data taken from memory instead of the ALU |
| branch_o | output | 1 | Conditional branch, qualified by the ALU zero flag downstream |
| jump_o | output | 1 | Unconditional jump target selected for the PC |
| alu_class_o | output | 2 | ALU class: 00 add, 01 subtract, 10 function-field decode |
| alu_op_o | output | 4 | ALU operation code |

## Verification
The block has no state, so a decode error shows at the ports in the same cycle the fields are applied. If a table entry is wrong, one instruction kind gets a wrong enable or ALU code. The most harmful case is an unknown opcode or function code that leaves a write enable high. That would corrupt a register or memory location on the very next clock edge. For that reason the bench sweeps every unused opcode and every unused function code, and checks that the function field has no effect outside register-register instructions.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;

  localparam int unsigned OP_W   = 6;
  localparam int unsigned FN_W   = 6;
  localparam int unsigned CLS_W  = 2;
  localparam int unsigned ALUC_W = 4;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OPC_LW    = 6'h23;
  localparam logic [OP_W-1:0] OPC_SW    = 6'h2B;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OPC_J     = 6'h02;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  typedef enum logic [CLS_W-1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10,
    CLS_RSVD  = 2'b11
  } alu_cls_e;

  typedef enum logic [ALUC_W-1:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_BAD = 4'b1111
  } alu_op_e;

  typedef struct packed {
    logic     dest_sel_rd;
    logic     rf_wr_en;
    logic     alu_src_imm;
    logic     mem_rd_en;
    logic     mem_wr_en;
    logic     wb_sel_mem;
    logic     branch;
    logic     jump;
    alu_cls_e alu_cls;
  } ctrl_t;

  localparam ctrl_t CTRL_NOP = '{
    dest_sel_rd: 1'b0, rf_wr_en: 1'b0, alu_src_imm: 1'b0, mem_rd_en: 1'b0,
    mem_wr_en: 1'b0, wb_sel_mem: 1'b0, branch: 1'b0, jump: 1'b0,
    alu_cls: CLS_ADD
  };

endpackage

// File: rtl/ctrl_main_dec.sv
module ctrl_main_dec
  import ctrl_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output ctrl_t           ctrl_o,
  output logic            is_rtype_o
);

  always_comb begin
    ctrl_o     = CTRL_NOP;
    is_rtype_o = 1'b0;
    unique case (opcode_i)
      OPC_RTYPE: begin
        is_rtype_o         = 1'b1;
        ctrl_o.dest_sel_rd = 1'b1;
        ctrl_o.rf_wr_en    = 1'b1;
        ctrl_o.alu_cls     = CLS_FUNCT;
      end
      OPC_LW: begin
        ctrl_o.rf_wr_en    = 1'b1;
        ctrl_o.alu_src_imm = 1'b1;
        ctrl_o.mem_rd_en   = 1'b1;
        ctrl_o.wb_sel_mem  = 1'b1;
      end
      OPC_SW: begin
        ctrl_o.alu_src_imm = 1'b1;
        ctrl_o.mem_wr_en   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl_o.branch  = 1'b1;
        ctrl_o.alu_cls = CLS_SUB;
      end
      OPC_J: begin
        ctrl_o.jump = 1'b1;
      end
      default: ctrl_o = CTRL_NOP;
    endcase
  end

  // at most one memory or flow action per instruction
  always_comb begin
    p_one_action_r8: assert ($onehot0({ctrl_o.mem_rd_en, ctrl_o.mem_wr_en,
                                       ctrl_o.branch, ctrl_o.jump}))
      else $error("more than one action for opcode %h", opcode_i);
  end

endmodule

// File: rtl/ctrl_alu_dec.sv
module ctrl_alu_dec
  import ctrl_pkg::*;
(
  input  alu_cls_e          alu_cls_i,
  input  logic [FN_W-1:0]   funct_i,
  output alu_op_e           alu_op_o,
  output logic              fn_ok_o
);

  alu_op_e fn_op;
  logic    fn_hit;

  always_comb begin
    fn_hit = 1'b1;
    unique case (funct_i)
      FN_ADD:  fn_op = ALU_ADD;
      FN_SUB:  fn_op = ALU_SUB;
      FN_AND:  fn_op = ALU_AND;
      FN_OR:   fn_op = ALU_OR;
      FN_SLT:  fn_op = ALU_SLT;
      default: begin
        fn_op  = ALU_BAD;
        fn_hit = 1'b0;
      end
    endcase
  end

  // function field only matters for the decode class
  always_comb begin
    fn_ok_o = 1'b1;
    unique case (alu_cls_i)
      CLS_ADD:   alu_op_o = ALU_ADD;
      CLS_SUB:   alu_op_o = ALU_SUB;
      CLS_FUNCT: begin
        alu_op_o = fn_op;
        fn_ok_o  = fn_hit;
      end
      default: begin
        alu_op_o = ALU_BAD;
        fn_ok_o  = 1'b0;
      end
    endcase
  end

  always_comb begin
    p_fixed_cls_r9: assert (alu_cls_i == CLS_FUNCT || alu_op_o != fn_op ||
                            fn_op == ALU_ADD || fn_op == ALU_SUB)
      else $error("function field leaked into fixed class");
  end

endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
  import ctrl_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output logic       dest_sel_rd_o,
  output logic       rf_wr_en_o,
  output logic       alu_src_imm_o,
  output logic       mem_rd_en_o,
  output logic       mem_wr_en_o,
  output logic       wb_sel_mem_o,
  output logic       branch_o,
  output logic       jump_o,
  output logic [1:0] alu_class_o,
  output logic [3:0] alu_op_o
);

  ctrl_t   ctrl;
  logic    is_rtype;
  alu_op_e alu_op;
  logic    fn_ok;

  ctrl_main_dec u_main (
    .opcode_i   (opcode_i),
    .ctrl_o     (ctrl),
    .is_rtype_o (is_rtype)
  );

  ctrl_alu_dec u_alu (
    .alu_cls_i (ctrl.alu_cls),
    .funct_i   (funct_i),
    .alu_op_o  (alu_op),
    .fn_ok_o   (fn_ok)
  );

  // unknown function code must not reach architectural state
  assign rf_wr_en_o    = ctrl.rf_wr_en & fn_ok;
  assign mem_wr_en_o   = ctrl.mem_wr_en & fn_ok;
  assign dest_sel_rd_o = ctrl.dest_sel_rd;
  assign alu_src_imm_o = ctrl.alu_src_imm;
  assign mem_rd_en_o   = ctrl.mem_rd_en;
  assign wb_sel_mem_o  = ctrl.wb_sel_mem;
  assign branch_o      = ctrl.branch;
  assign jump_o        = ctrl.jump;
  assign alu_class_o   = ctrl.alu_cls;
  assign alu_op_o      = alu_op;

  always_comb begin
    p_rtype_dst_r1: assert (!dest_sel_rd_o || (alu_class_o == 2'b10 && !alu_src_imm_o))
      else $error("rd destination without function decode");
    p_bad_fn_r3: assert (!(is_rtype && alu_op_o == 4'b1111) || (!rf_wr_en_o && !mem_wr_en_o))
      else $error("write enabled on bad function code");
    p_imm_add_r4: assert (!alu_src_imm_o || alu_op_o == 4'b0010)
      else $error("immediate operand without add");
    p_store_no_wb_r5: assert (!mem_wr_en_o || (!rf_wr_en_o && !mem_rd_en_o))
      else $error("store also writes back");
    p_branch_sub_r6: assert (!branch_o || (alu_op_o == 4'b0110 && !rf_wr_en_o))
      else $error("branch without subtract");
    p_jump_quiet_r7: assert (!jump_o || (!rf_wr_en_o && !mem_wr_en_o))
      else $error("jump writes state");
  end

endmodule

// File: tb/ctrl_decoder_tb_top.sv
module ctrl_decoder_tb_top;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [5:0] opcode, funct;
  logic dest_sel_rd, rf_wr_en, alu_src_imm, mem_rd_en, mem_wr_en, wb_sel_mem;
  logic branch, jump;
  logic [1:0] alu_class;
  logic [3:0] alu_op;

  int n_vec = 0;
  int n_bad = 0;

  ctrl_decoder dut_i (
    .opcode_i      (opcode),
    .funct_i       (funct),
    .dest_sel_rd_o (dest_sel_rd),
    .rf_wr_en_o    (rf_wr_en),
    .alu_src_imm_o (alu_src_imm),
    .mem_rd_en_o   (mem_rd_en),
    .mem_wr_en_o   (mem_wr_en),
    .wb_sel_mem_o  (wb_sel_mem),
    .branch_o      (branch),
    .jump_o        (jump),
    .alu_class_o   (alu_class),
    .alu_op_o      (alu_op)
  );

  // packed order: dst,rfw,imm,mrd,mwr,wbm,br,j,cls[2],op[4]
  function automatic logic [13:0] pack_exp(logic d, logic w, logic i, logic r,
      logic m, logic b2, logic br, logic j, logic [1:0] c, logic [3:0] o);
    return {d, w, i, r, m, b2, br, j, c, o};
  endfunction

  task automatic apply_check(input logic [5:0] op, input logic [5:0] fn,
                             input logic [13:0] exp, input string req);
    logic [13:0] act;
    @(posedge clk);
    opcode = op;
    funct  = fn;
    @(negedge clk);
    act = {dest_sel_rd, rf_wr_en, alu_src_imm, mem_rd_en, mem_wr_en, wb_sel_mem,
           branch, jump, alu_class, alu_op};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%h fn=%h actual=%b expected=%b", req, op, fn, act, exp);
    end
  endtask

  function automatic logic [13:0] rtype_exp(logic [5:0] fn);
    case (fn)
      6'h20: return pack_exp(1,1,0,0,0,0,0,0,2'b10,4'b0010);
      6'h22: return pack_exp(1,1,0,0,0,0,0,0,2'b10,4'b0110);
      6'h24: return pack_exp(1,1,0,0,0,0,0,0,2'b10,4'b0000);
      6'h25: return pack_exp(1,1,0,0,0,0,0,0,2'b10,4'b0001);
      6'h2A: return pack_exp(1,1,0,0,0,0,0,0,2'b10,4'b0111);
      default: return pack_exp(1,0,0,0,0,0,0,0,2'b10,4'b1111);
    endcase
  endfunction

  task automatic t_reset_state();
    // all-zero fields: register-register with unknown function code
    apply_check(6'h00, 6'h00, pack_exp(1,0,0,0,0,0,0,0,2'b10,4'b1111), "R3 reset-state");
  endtask

  task automatic t_rtype_known();
    apply_check(6'h00, 6'h20, rtype_exp(6'h20), "R1 add controls");
    apply_check(6'h00, 6'h20, rtype_exp(6'h20), "R2 add");
    apply_check(6'h00, 6'h22, rtype_exp(6'h22), "R2 sub");
    apply_check(6'h00, 6'h24, rtype_exp(6'h24), "R2 and");
    apply_check(6'h00, 6'h25, rtype_exp(6'h25), "R2 or");
    apply_check(6'h00, 6'h2A, rtype_exp(6'h2A), "R2 slt");
  endtask

  task automatic t_rtype_unknown();
    for (int f = 0; f < 64; f++) begin
      if (!(f inside {'h20, 'h22, 'h24, 'h25, 'h2A}))
        apply_check(6'h00, 6'(f), rtype_exp(6'(f)), "R3 bad funct");
    end
  endtask

  task automatic t_load();
    apply_check(6'h23, 6'h20, pack_exp(0,1,1,1,0,1,0,0,2'b00,4'b0010), "R4 lw");
  endtask

  task automatic t_store();
    apply_check(6'h2B, 6'h20, pack_exp(0,0,1,0,1,0,0,0,2'b00,4'b0010), "R5 sw");
  endtask

  task automatic t_branch();
    apply_check(6'h04, 6'h20, pack_exp(0,0,0,0,0,0,1,0,2'b01,4'b0110), "R6 beq");
  endtask

  task automatic t_jump();
    apply_check(6'h02, 6'h20, pack_exp(0,0,0,0,0,0,0,1,2'b00,4'b0010), "R7 j");
  endtask

  task automatic t_bad_opcode();
    for (int o = 0; o < 64; o++) begin
      if (!(o inside {'h00, 'h23, 'h2B, 'h04, 'h02}))
        apply_check(6'(o), 6'h2A, pack_exp(0,0,0,0,0,0,0,0,2'b00,4'b0010), "R8 bad opcode");
    end
  endtask

  task automatic t_funct_ignored();
    logic [5:0] fns [4] = '{6'h22, 6'h3F, 6'h2A, 6'h00};
    foreach (fns[k]) begin
      apply_check(6'h23, fns[k], pack_exp(0,1,1,1,0,1,0,0,2'b00,4'b0010), "R9 lw funct");
      apply_check(6'h2B, fns[k], pack_exp(0,0,1,0,1,0,0,0,2'b00,4'b0010), "R9 sw funct");
      apply_check(6'h04, fns[k], pack_exp(0,0,0,0,0,0,1,0,2'b01,4'b0110), "R9 beq funct");
      apply_check(6'h02, fns[k], pack_exp(0,0,0,0,0,0,0,1,2'b00,4'b0010), "R9 j funct");
      apply_check(6'h3F, fns[k], pack_exp(0,0,0,0,0,0,0,0,2'b00,4'b0010), "R9 bad-op funct");
    end
  endtask

  logic done = 1'b0;

  initial begin
    opcode = 6'h00;
    funct  = 6'h00;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_rtype_known();
    t_rtype_unknown();
    t_load();
    t_store();
    t_branch();
    t_jump();
    t_bad_opcode();
    t_funct_ignored();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule